// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block is the transmit half of the controller side of a time-slotted serial audio link. It runs from the link bit clock and produces two outputs: the frame sync and the serial data line. Each frame is 256 bit times long. It opens with a 16-bit tag slot, and twelve 20-bit slots follow it. Slot 1 carries a command address, slot 2 carries command data, and slots 3 to 12 carry PCM sample words. A producer supplies every word in parallel, together with a valid flag per slot and a 2-bit codec ID.

At the first edge of each frame the block does three things. It builds the tag from the valid flags and the ID. It replaces the word of every slot not marked valid with zeros. It loads the whole frame into one register, which then shifts out MSB first, one bit per rising clock edge. The receiver samples each bit on the falling edge that follows. A one-cycle `frame_start` strobe opens every frame. After that strobe the producer is free to present the words for the next frame.

To access a secondary codec, the producer sets a non-zero codec ID. The block then marks the frame valid even when no slot is valid.

Top module: `aframe_tx`

## Requirements
- R1: While `rst_n` is low, `sync`, `sdata` and `frame_start` are low from the next clock edge on. The first clock edge with `rst_n` high starts a frame: `frame_start` and `sync` are high in the cycle after that edge.
- R2: Consecutive `frame_start` pulses are exactly 256 clock cycles apart.
- R3: `sync` goes high in the same cycle as `frame_start` and stays high for exactly 16 cycles. It is low for the other 240 cycles of the frame.
- R4: Tag bit 15 (frame valid) is 1 exactly when at least one slot valid flag is set or `codec_id` is non-zero.
- R5: Tag bits 14 down to 3 carry the valid flags of slots 1 to 12 in that order. Bit 14 is `cmd_addr_vld`, bit 13 is `cmd_data_vld`, and bit 12-k is `pcm_vld[k]` (PCM word k goes in slot k+3).
- R6: Tag bit 2 is always 0, and tag bits 1:0 equal `codec_id`.
- R7: The frame is sent MSB first. The 16 tag bits come first, then the slots 1 to 12 at 20 bits each. A valid slot carries its word exactly. Slot 1 is `cmd_addr`, slot 2 is `cmd_data`, and slot k+3 is `pcm_data[k*20 +: 20]`.
- R8: Every bit of a slot whose valid flag is clear is sent as 0, whatever its data input holds.
- R9: With no valid flag set and a non-zero `codec_id`, the tag is 0x8000 ORed with the ID, and every slot bit is 0.
- R10: The block samples its inputs only on the frame's first edge, which is the edge after which `frame_start` is high. Input changes at any other time do not alter the frame being sent.
- R11: Frame position p (p = 0 is frame valid) appears on `sdata` in cycle p+1, counting the `frame_start` cycle as cycle 0. The last bit of a frame is on the line in the cycle in which the next `frame_start` is high.
- R12: `frame_start` is high for one cycle only, per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| codec_id | input | 2 | Codec ID placed in tag bits 1:0 |
| cmd_addr | input | 20 | Slot 1 word (command address) |
| cmd_addr_vld | input | 1 | Slot 1 valid flag |
| cmd_data | input | 20 | Slot 2 word (command data) |
| cmd_data_vld | input | 1 | Slot 2 valid flag |
| pcm_data | input | 200 | Ten PCM words, word k at bits k*20+19..k*20, sent in slot k+3 |
| pcm_vld | input | 10 | Valid flag of each PCM word |
| sync | output | 1 | Frame sync, high for the first 16 cycles of a frame |
| sdata | output | 1 | Serial frame data, MSB first |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |

## Verification
In the first cycle of a frame, two things happen on the same edge: the last bit of the old frame (the slot 12 LSB) is driven, and the new inputs are loaded into the register that holds that bit. The bench provokes this by presenting new words for the next frame long before that edge and by making the slot 12 LSB of the outgoing frame differ from the incoming data. It judges the result by checking that the bit on the line in the `frame_start` cycle is still the old frame's last bit, and that frame valid of the new tag follows one cycle later. Some frames also get unrelated input values in the middle of the frame, to show that sampling happens only at that one edge.

// File: rtl/aframe_pkg.sv
// Package: shared sizing helpers for the audio frame serializer.
// Assumes the tag layout: frame valid, one valid bit per slot, one pad
// zero, then the codec ID in the low bits.
package aframe_pkg;

    // Width of the tag slot for a given slot count and codec ID width.
    function automatic int tag_width(input int n_slots, input int id_w);
        return 1 + n_slots + 1 + id_w;
    endfunction

    // Total bits of one frame.
    function automatic int frame_width(input int n_slots, input int id_w,
                                       input int slot_w);
        return tag_width(n_slots, id_w) + n_slots * slot_w;
    endfunction

endpackage

// File: rtl/aframe_timer.sv
// Module: frame timer.
// Runs a free bit counter over one frame. In the cycle after the
// counter-zero edge it raises frame_start, and it keeps sync high for
// SYNC_LEN cycles from that point. load is high during the counter-zero
// cycle so that the shifter reloads on the frame's first edge.
// Assumes FRAME_BITS > SYNC_LEN > 1.
module aframe_timer #(
    parameter int FRAME_BITS = 256,
    parameter int SYNC_LEN   = 16,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    output logic load,
    output logic sync,
    output logic frame_start
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN);

    logic [CNT_W-1:0] bit_cnt;

    // Load request: the counter-zero cycle is the frame's first edge.
    assign load = (bit_cnt == '0);

    // Bit counter: counts positions within the frame and wraps at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (bit_cnt == LAST_POS) begin
            bit_cnt <= '0;
        end else begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Frame markers: sync covers the tag window, frame_start marks its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync        <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            sync        <= (bit_cnt < SYNC_END);
            frame_start <= (bit_cnt == '0);
        end
    end

endmodule

// File: rtl/aframe_tag_builder.sv
// Module: tag slot builder.
// Combinational. It orders the per-slot valid flags into the tag, derives
// frame valid from those flags and the codec ID, and adds the pad zero.
// Assumes slot_vld[0] belongs to slot 1.
module aframe_tag_builder #(
    parameter int N_SLOTS = 12,
    parameter int ID_W    = 2,
    localparam int TAG_W  = aframe_pkg::tag_width(N_SLOTS, ID_W)
) (
    input  logic [N_SLOTS-1:0] slot_vld,
    input  logic [ID_W-1:0]    codec_id,
    output logic [TAG_W-1:0]   tag
);

    logic frame_valid;

    // Frame valid: any slot in use, or a secondary codec addressed.
    assign frame_valid = (|slot_vld) || (|codec_id);

    // Tag assembly: slot 1 flag goes just below frame valid.
    always_comb begin
        tag            = '0;
        tag[TAG_W-1]   = frame_valid;
        for (int i = 0; i < N_SLOTS; i++) begin
            tag[TAG_W-2-i] = slot_vld[i];
        end
        tag[ID_W]      = 1'b0;
        tag[ID_W-1:0]  = codec_id;
    end

endmodule

// File: rtl/aframe_slot_pack.sv
// Module: frame image packer.
// Combinational. It places the tag at the top of the frame image and puts
// the slot words below it, slot 1 first. Every slot not marked valid is
// replaced by zeros.
// Assumes slot_word holds slot i+1 at bits [i*SLOT_W +: SLOT_W].
module aframe_slot_pack #(
    parameter int SLOT_W     = 20,
    parameter int N_SLOTS    = 12,
    parameter int ID_W       = 2,
    localparam int TAG_W     = aframe_pkg::tag_width(N_SLOTS, ID_W),
    localparam int FRAME_BITS = aframe_pkg::frame_width(N_SLOTS, ID_W, SLOT_W)
) (
    input  logic [TAG_W-1:0]          tag,
    input  logic [N_SLOTS-1:0]        slot_vld,
    input  logic [N_SLOTS*SLOT_W-1:0] slot_word,
    output logic [FRAME_BITS-1:0]     frame_img
);

    logic [N_SLOTS*SLOT_W-1:0] stuffed;

    // Zero-stuffing: one gate row per slot.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign stuffed[g*SLOT_W +: SLOT_W] =
            slot_vld[g] ? slot_word[g*SLOT_W +: SLOT_W] : '0;
    end

    // Image layout: tag, then slot 1 down to slot N in sending order.
    always_comb begin
        frame_img = '0;
        frame_img[FRAME_BITS-1 -: TAG_W] = tag;
        for (int i = 0; i < N_SLOTS; i++) begin
            frame_img[FRAME_BITS-1-TAG_W-i*SLOT_W -: SLOT_W] =
                stuffed[i*SLOT_W +: SLOT_W];
        end
    end

endmodule

// File: rtl/aframe_shifter.sv
// Module: frame shadow and shifter.
// A single register holds the frame being sent. It loads the new image on
// the load cycle and otherwise shifts left, with the top bit registered
// onto the serial line. Because load and the final bit fall on the same
// edge, the last bit of a frame is sent from the old contents.
// Assumes load occurs once every FRAME_BITS cycles.
module aframe_shifter #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_img,
    output logic                  sdata
);

    logic [FRAME_BITS-1:0] shreg;

    // Shadow register: capture at frame start, shift one place per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= frame_img;
        end else begin
            shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        end
    end

    // Line driver: register the current top bit onto sdata.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata <= 1'b0;
        end else begin
            sdata <= shreg[FRAME_BITS-1];
        end
    end

endmodule

// File: rtl/aframe_tx.sv
// Module: audio link output frame serializer (top).
// Gathers the command and PCM words and their valid flags into one slot
// vector, builds the tag, zero-stuffs the slots, and sends each frame on
// sdata with sync and frame_start. Everything runs on the rising edge of
// the bit clock. The receiver is assumed to sample on the falling edge.
module aframe_tx #(
    parameter int SLOT_W = 20,
    parameter int N_PCM  = 10,
    parameter int ID_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         codec_id,
    input  logic [SLOT_W-1:0]       cmd_addr,
    input  logic                    cmd_addr_vld,
    input  logic [SLOT_W-1:0]       cmd_data,
    input  logic                    cmd_data_vld,
    input  logic [N_PCM*SLOT_W-1:0] pcm_data,
    input  logic [N_PCM-1:0]        pcm_vld,
    output logic                    sync,
    output logic                    sdata,
    output logic                    frame_start
);

    localparam int N_SLOTS    = N_PCM + 2;
    localparam int TAG_W      = aframe_pkg::tag_width(N_SLOTS, ID_W);
    localparam int FRAME_BITS = aframe_pkg::frame_width(N_SLOTS, ID_W, SLOT_W);

    logic [N_SLOTS-1:0]        slot_vld;
    logic [N_SLOTS*SLOT_W-1:0] slot_word;
    logic [TAG_W-1:0]          tag;
    logic [FRAME_BITS-1:0]     frame_img;
    logic                      load;

    // Slot vector: command address, command data, then the PCM words.
    assign slot_vld  = {pcm_vld, cmd_data_vld, cmd_addr_vld};
    assign slot_word = {pcm_data, cmd_data, cmd_addr};

    aframe_timer #(
        .FRAME_BITS (FRAME_BITS),
        .SYNC_LEN   (TAG_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .sync        (sync),
        .frame_start (frame_start)
    );

    aframe_tag_builder #(
        .N_SLOTS (N_SLOTS),
        .ID_W    (ID_W)
    ) u_tag (
        .slot_vld (slot_vld),
        .codec_id (codec_id),
        .tag      (tag)
    );

    aframe_slot_pack #(
        .SLOT_W  (SLOT_W),
        .N_SLOTS (N_SLOTS),
        .ID_W    (ID_W)
    ) u_pack (
        .tag       (tag),
        .slot_vld  (slot_vld),
        .slot_word (slot_word),
        .frame_img (frame_img)
    );

    aframe_shifter #(
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .frame_img (frame_img),
        .sdata     (sdata)
    );

endmodule

// File: rtl/aframe_tx_chk.sv
// Module: port-level checker for aframe_tx, attached with bind.
// It tracks the cycles since the last frame_start, plus the frame-valid
// value implied by the inputs at the capture edge. It watches only ports.
module aframe_tx_chk #(
    parameter int SLOT_W = 20,
    parameter int N_PCM  = 10,
    parameter int ID_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ID_W-1:0]  codec_id,
    input logic             cmd_addr_vld,
    input logic             cmd_data_vld,
    input logic [N_PCM-1:0] pcm_vld,
    input logic             sync,
    input logic             sdata,
    input logic             frame_start
);

    localparam int N_SLOTS    = N_PCM + 2;
    localparam int TAG_W      = aframe_pkg::tag_width(N_SLOTS, ID_W);
    localparam int FRAME_BITS = aframe_pkg::frame_width(N_SLOTS, ID_W, SLOT_W);
    localparam int SW         = $clog2(FRAME_BITS) + 2;
    localparam logic [SW-1:0] SINCE_MAX = '1;

    logic          seen;
    logic [SW-1:0] since;
    logic          pend_fv;

    // Gap tracker: cycles since the last frame_start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            since <= '0;
        end else begin
            if (frame_start) begin
                seen  <= 1'b1;
                since <= SW'(1);
            end else if (since != SINCE_MAX) begin
                since <= since + 1'b1;
            end
        end
    end

    // Input sampler: frame valid implied by the inputs seen at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_fv <= 1'b0;
        end else begin
            pend_fv <= cmd_addr_vld || cmd_data_vld || (|pcm_vld) || (|codec_id);
        end
    end

    // R1: reset forces the outputs low.
    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sync && !sdata && !frame_start));

    // R2: frame period.
    p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen) |-> (since == SW'(FRAME_BITS)));

    // R12: single-cycle strobe.
    p_start_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R3: sync rises with frame_start.
    p_sync_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> sync);

    // R3: sync covers exactly the tag window.
    p_sync_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !frame_start) |-> (sync == (since < SW'(TAG_W))));

    // R4, R11: frame valid leads the frame one cycle after frame_start.
    p_fv_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (sdata == $past(pend_fv)));

    // R6: pad bit of the tag is zero.
    p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !frame_start && since == SW'(TAG_W - ID_W)) |-> !sdata);

endmodule

bind aframe_tx aframe_tx_chk #(
    .SLOT_W (SLOT_W),
    .N_PCM  (N_PCM),
    .ID_W   (ID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .codec_id     (codec_id),
    .cmd_addr_vld (cmd_addr_vld),
    .cmd_data_vld (cmd_data_vld),
    .pcm_vld      (pcm_vld),
    .sync         (sync),
    .sdata        (sdata),
    .frame_start  (frame_start)
);

// File: tb/test_aframe_tx.sv
module test_aframe_tx;

    localparam int FB = 256;

    typedef struct packed {
        logic [1:0]   id;
        logic         av;
        logic [19:0]  a;
        logic         dv;
        logic [19:0]  d;
        logic [9:0]   pv;
        logic [199:0] p;
    } stim_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   codec_id;
    logic [19:0]  cmd_addr;
    logic         cmd_addr_vld;
    logic [19:0]  cmd_data;
    logic         cmd_data_vld;
    logic [199:0] pcm_data;
    logic [9:0]   pcm_vld;
    logic         sync;
    logic         sdata;
    logic         frame_start;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    stim_t cur;

    always #10 clk = ~clk;

    aframe_tx i_aframe_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .codec_id     (codec_id),
        .cmd_addr     (cmd_addr),
        .cmd_addr_vld (cmd_addr_vld),
        .cmd_data     (cmd_data),
        .cmd_data_vld (cmd_data_vld),
        .pcm_data     (pcm_data),
        .pcm_vld      (pcm_vld),
        .sync         (sync),
        .sdata        (sdata),
        .frame_start  (frame_start)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic drive(input stim_t s);
        codec_id     = s.id;
        cmd_addr     = s.a;
        cmd_addr_vld = s.av;
        cmd_data     = s.d;
        cmd_data_vld = s.dv;
        pcm_data     = s.p;
        pcm_vld      = s.pv;
    endtask

    function automatic stim_t rand_stim();
        stim_t s;
        s.id = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
        s.av = 1'($urandom);
        s.a  = 20'($urandom);
        s.dv = 1'($urandom);
        s.d  = 20'($urandom);
        s.pv = 10'($urandom);
        for (int k = 0; k < 10; k++) s.p[k*20 +: 20] = 20'($urandom);
        return s;
    endfunction

    // Valid flags in slot order, slot 1 at bit 11 (R5).
    function automatic logic [11:0] slot_flags(input stim_t s);
        logic [11:0] v;
        v[11] = s.av;
        v[10] = s.dv;
        for (int k = 0; k < 10; k++) v[9-k] = s.pv[k];
        return v;
    endfunction

    // Expected frame, bit 255 = first bit on the line (R4-R9).
    function automatic logic [FB-1:0] exp_frame(input stim_t s);
        logic [11:0]  v;
        logic [15:0]  tg;
        logic [239:0] body;
        logic [19:0]  w;
        v  = slot_flags(s);
        tg = {(|v) | (s.id != 2'd0), v, 1'b0, s.id};
        for (int k = 0; k < 12; k++) begin
            if (k == 0)      w = s.a;
            else if (k == 1) w = s.d;
            else             w = s.p[(k-2)*20 +: 20];
            body[239-20*k -: 20] = v[11-k] ? w : 20'd0;
        end
        return {tg, body};
    endfunction

    // Send one frame's worth of checks; on entry frame_start is high for cur.
    task automatic run_frame(input stim_t nxt, input bit garble, input string lbl);
        logic [FB-1:0] obs;
        logic [FB-1:0] expf;
        logic [11:0]   v;
        int sync_bad = 0;
        int fs_bad   = 0;
        logic fv_first;
        drive(nxt);
        for (int j = 1; j <= FB; j++) begin
            @(negedge clk);
            obs[FB-j] = sdata;
            if (j == 1) fv_first = sdata;
            if (j < FB) begin
                if (sync !== (j < 16)) sync_bad++;
                if (frame_start !== 1'b0) fs_bad++;
            end
            if (garble && j == 100) drive(rand_stim());
            if (garble && j == 200) drive(nxt);
        end
        expf = exp_frame(cur);
        v    = slot_flags(cur);
        chk("R3", {lbl, " sync window errors"}, sync_bad, 0);
        chk("R12", {lbl, " extra frame_start"}, fs_bad, 0);
        chk("R2", {lbl, " frame_start after 256"}, frame_start, 1);
        chk("R3", {lbl, " sync at next start"}, sync, 1);
        chk("R11", {lbl, " frame valid first"}, fv_first, expf[FB-1]);
        chk("R4", {lbl, " frame valid"}, obs[255], expf[255]);
        chk("R5", {lbl, " slot flags"}, obs[254:243], expf[254:243]);
        chk("R6", {lbl, " pad and id"}, obs[242:240], expf[242:240]);
        for (int k = 0; k < 12; k++) begin
            chk(garble ? "R10" : (v[11-k] ? "R7" : "R8"),
                $sformatf("%s slot %0d", lbl, k+1),
                obs[239-20*k -: 20], expf[239-20*k -: 20]);
        end
        cur = nxt;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        stim_t s0, s1, s2, s3, s4;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        s0.id = 2'd0; s0.av = 1'b1; s0.a = 20'hA5A5A; s0.dv = 1'b1; s0.d = 20'h12345;
        s0.pv = 10'h3FF;
        for (int k = 0; k < 10; k++) s0.p[k*20 +: 20] = 20'h10001 + 20'(k * 20'h01111);
        drive(s0);
        repeat (4) @(negedge clk);
        chk("R1", "outputs in reset", {29'd0, sync, sdata, frame_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first start after reset", {30'd0, frame_start, sync}, 3);
        cur = s0;
        // no slot valid, id 0: all zero
        s1 = rand_stim(); s1.id = 2'd0; s1.av = 1'b0; s1.dv = 1'b0; s1.pv = '0;
        run_frame(s1, 1'b0, "all-valid");
        // secondary access only (R9)
        s2 = rand_stim(); s2.id = 2'd2; s2.av = 1'b0; s2.dv = 1'b0; s2.pv = '0;
        run_frame(s2, 1'b0, "empty");
        // only slot 12 valid, word with MSB and LSB set
        s3 = rand_stim(); s3.id = 2'd0; s3.av = 1'b0; s3.dv = 1'b0; s3.pv = 10'h200;
        s3.p[9*20 +: 20] = 20'h80001;
        run_frame(s3, 1'b0, "R9 secondary");
        s4 = rand_stim(); s4.id = 2'd3; s4.av = 1'b1; s4.dv = 1'b0; s4.pv = '0;
        run_frame(s4, 1'b1, "slot12-only");
        for (int f = 0; f < 10; f++) begin
            run_frame(rand_stim(), (f % 3) == 0, $sformatf("rand%0d", f));
        end
        run_frame(rand_stim(), 1'b0, "last");
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "outputs after mid-frame reset", {29'd0, sync, sdata, frame_start}, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule